// File: doc/BRIEF.md
# Indirect-Access Network Controller Register Bank

This block is the host-visible register file of a network controller. The host sees only two 16-bit words. Writing the select word (offset 1) chooses one internal register. The data word (offset 0) then reads or writes the chosen register. The bank holds:

- the main command/status register;
- the two halves of the initialization-block address;
- a byte-order and bus control register;
- four multicast filter words;
- a mode register carrying a promiscuous-receive bit.

In the command/status register each bit has its own access rule. Command bits act when a one is written and drive one-cycle pulses to the transmit and receive ring engines. The run state is read-only. The interrupt enable is read/write. Event flags are set by the engines and cleared when the host writes a one to them. A summary error bit and an interrupt output are derived from the flags.

A stop command overrides everything else written with it. It forces the register back to its stopped value and clears the byte-order register. The ring engines and the MAC sit outside this block. They receive the command pulses, the run status and the configuration outputs, and they report events on single-cycle inputs.

Top module: `netctl_regbank`

## Requirements
- R1: A write with `host_addr`=1 loads the low 4 bits of `host_wdata` into the select register. A read with `host_addr`=1 returns the select value zero-extended. A read or write with `host_addr`=0 accesses the register picked by the select value.
- R2: After reset, register 0 reads 0x0004 (only the stop bit set) and the select register reads 0. All other registers and outputs are zero, with no command pulse and `irq_o` low.
- R3: A write to register 0 with bit 2 clear produces a pulse in the following cycle for each of bit 0 (`cmd_init`), bit 1 (`cmd_start`) and bit 3 (`cmd_tx_demand`) that is written as one. Each pulse lasts exactly one cycle. Bits 0 and 3 always read 0.
- R4: A write to register 0 with bit 2 set pulses only `cmd_stop`. The start, init and transmit-demand requests in the same word are ignored. Register 0 then reads exactly 0x0004: run, transmit-on, receive-on, enable and all flags are cleared. Register 3 is also cleared. This holds provided no event arrives in the same cycle.
- R5: Writing bit 1 (start) without bit 2 clears the stop bit (bit 2) and sets bit 1, bit 4 (transmit on) and bit 5 (receive on). The `tx_on` and `rx_on` outputs rise with bits 4 and 5.
- R6: Bit 6 (interrupt enable) takes the written value on every register-0 write that lacks bit 2. Writes to bits 4, 5 and 7 have no effect.
- R7: The event inputs set flags in register 0: init-done bit 8, transmit bit 9, receive bit 10, memory error bit 11, missed frame bit 12, carrier error bit 13, babble bit 14. Writing one to a flag clears it and writing zero leaves it unchanged. An event in the same cycle as a clear leaves the flag set.
- R8: Bit 15 reads as the OR of bits 11 to 14. Bit 7 reads as the OR of bits 8 to 14. `irq_o` equals bit 7 AND bit 6.
- R9: Registers 1 and 2 are full 16-bit read/write words. `init_addr` presents register 2 in its upper half and register 1 in its lower half.
- R10: In register 3 only bits 2:0 are writable; bits 15:3 read 0. The value drives `bus_ctl`.
- R11: Registers 8 to 11 are 16-bit read/write filter words. `mcast_filter` presents register 8 in bits 15:0 up to register 11 in bits 63:48.
- R12: In register 15 only bit 15 is writable; it drives `promisc`. Selects with no register behind them read 0, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 1 | 0 = data word, 1 = select word |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data (combinational) |
| ev_init_done | input | 1 | Initialization finished event |
| ev_tx_int | input | 1 | Transmit completion event |
| ev_rx_int | input | 1 | Receive completion event |
| ev_mem_err | input | 1 | Memory access error event |
| ev_missed | input | 1 | Missed frame event |
| ev_carrier_err | input | 1 | Carrier error event |
| ev_babble | input | 1 | Transmit babble event |
| cmd_init | output | 1 | One-cycle initialize request |
| cmd_start | output | 1 | One-cycle start request |
| cmd_stop | output | 1 | One-cycle stop request |
| cmd_tx_demand | output | 1 | One-cycle transmit poll request |
| tx_on | output | 1 | Transmitter running |
| rx_on | output | 1 | Receiver running |
| irq_o | output | 1 | Interrupt request |
| init_addr | output | 32 | Initialization-block address |
| bus_ctl | output | 3 | Byte-order and bus control bits |
| mcast_filter | output | 64 | Multicast filter words |
| promisc | output | 1 | Promiscuous receive enable |

## Verification
A wrong flag or enable state appears at the data port and on `irq_o` at the first read after the offending edge. The summary bits are combinational from stored flags, so a corrupted flag cannot hide behind a correct summary. A wrong run state shows on `tx_on` and `rx_on` in the same cycle. A misrouted command appears as a stray or missing pulse exactly one cycle after the write. A missed clear of the byte-order register after a stop is visible on `bus_ctl` immediately. Directed sequences cover stop overriding init, an event colliding with its own clear, and interrupts with the enable off.

// File: rtl/netctl_pkg.sv
package netctl_pkg;
    localparam int DW    = 16;
    localparam int NFLAG = 7;

    // command bit positions within the control word
    localparam int CB_INIT = 0;
    localparam int CB_STRT = 1;
    localparam int CB_STOP = 2;
    localparam int CB_TDMD = 3;
    localparam int CB_INEA = 6;
    localparam int FLAG_LSB = 8;

    // register indices behind the select word
    localparam int REG_CTRL    = 0;
    localparam int REG_ADDR_LO = 1;
    localparam int REG_ADDR_HI = 2;
    localparam int REG_BUS     = 3;
    localparam int REG_MODE    = 15;
    localparam int BUS_W       = 3;

    typedef struct packed {
        logic init;
        logic start;
        logic stop;
        logic tdmd;
    } cmd_t;
endpackage

// File: rtl/netctl_csr0.sv
module netctl_csr0
    import netctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [3:0]       cmd_bits,
    input  logic             inea_bit,
    input  logic [NFLAG-1:0] clr_bits,
    input  logic [NFLAG-1:0] ev_set,
    output cmd_t             cmd_o,
    output logic             running,
    output logic             stopped,
    output logic             inea,
    output logic [NFLAG-1:0] flags
);
    typedef struct packed {
        logic             run;
        logic             stop;
        logic             inea;
        logic [NFLAG-1:0] flg;
        cmd_t             cmd;
    } csr0_t;

    csr0_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.cmd = '0;
        if (wr_en) begin
            if (cmd_bits[CB_STOP]) begin
                st_d.cmd.stop = 1'b1;
                st_d.stop     = 1'b1;
                st_d.run      = 1'b0;
                st_d.inea     = 1'b0;
                st_d.flg      = '0;
            end else begin
                st_d.cmd.init  = cmd_bits[CB_INIT];
                st_d.cmd.start = cmd_bits[CB_STRT];
                st_d.cmd.tdmd  = cmd_bits[CB_TDMD];
                if (cmd_bits[CB_STRT]) begin
                    st_d.run  = 1'b1;
                    st_d.stop = 1'b0;
                end
                st_d.inea = inea_bit;
                st_d.flg  = st_q.flg & ~clr_bits;
            end
        end
        // events always win over any clear in the same cycle
        st_d.flg = st_d.flg | ev_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.stop <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign cmd_o   = st_q.cmd;
    assign running = st_q.run;
    assign stopped = st_q.stop;
    assign inea    = st_q.inea;
    assign flags   = st_q.flg;
endmodule

// File: rtl/netctl_cfg_regs.sv
module netctl_cfg_regs
    import netctl_pkg::*;
#(
    parameter int SEL_W     = 4,
    parameter int NUM_FILT  = 4,
    parameter int FILT_BASE = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [SEL_W-1:0]       sel,
    input  logic [DW-1:0]          wdata,
    input  logic                   clear_bus,
    output logic [DW-1:0]          rdata,
    output logic [2*DW-1:0]        init_addr,
    output logic [BUS_W-1:0]       bus_ctl,
    output logic [NUM_FILT*DW-1:0] filt_o,
    output logic                   promisc
);
    typedef struct packed {
        logic [DW-1:0]                lo;
        logic [DW-1:0]                hi;
        logic [BUS_W-1:0]             bus;
        logic                         prom;
        logic [NUM_FILT-1:0][DW-1:0]  filt;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            if (sel == SEL_W'(REG_ADDR_LO)) cfg_d.lo   = wdata;
            if (sel == SEL_W'(REG_ADDR_HI)) cfg_d.hi   = wdata;
            if (sel == SEL_W'(REG_BUS))     cfg_d.bus  = wdata[BUS_W-1:0];
            if (sel == SEL_W'(REG_MODE))    cfg_d.prom = wdata[DW-1];
            for (int i = 0; i < NUM_FILT; i++) begin
                if (sel == SEL_W'(FILT_BASE + i)) cfg_d.filt[i] = wdata;
            end
        end
        if (clear_bus) cfg_d.bus = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    always_comb begin
        rdata = '0;
        if (sel == SEL_W'(REG_ADDR_LO)) rdata = cfg_q.lo;
        if (sel == SEL_W'(REG_ADDR_HI)) rdata = cfg_q.hi;
        if (sel == SEL_W'(REG_BUS))     rdata = {{(DW-BUS_W){1'b0}}, cfg_q.bus};
        if (sel == SEL_W'(REG_MODE))    rdata = {cfg_q.prom, {(DW-1){1'b0}}};
        for (int i = 0; i < NUM_FILT; i++) begin
            if (sel == SEL_W'(FILT_BASE + i)) rdata = cfg_q.filt[i];
        end
    end

    for (genvar g = 0; g < NUM_FILT; g++) begin : g_filt
        assign filt_o[g*DW +: DW] = cfg_q.filt[g];
    end

    assign init_addr = {cfg_q.hi, cfg_q.lo};
    assign bus_ctl   = cfg_q.bus;
    assign promisc   = cfg_q.prom;
endmodule

// File: rtl/netctl_regbank.sv
module netctl_regbank
    import netctl_pkg::*;
#(
    parameter int SEL_W     = 4,
    parameter int NUM_FILT  = 4,
    parameter int FILT_BASE = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   host_wr,
    input  logic                   host_addr,
    input  logic [15:0]            host_wdata,
    output logic [15:0]            host_rdata,
    input  logic                   ev_init_done,
    input  logic                   ev_tx_int,
    input  logic                   ev_rx_int,
    input  logic                   ev_mem_err,
    input  logic                   ev_missed,
    input  logic                   ev_carrier_err,
    input  logic                   ev_babble,
    output logic                   cmd_init,
    output logic                   cmd_start,
    output logic                   cmd_stop,
    output logic                   cmd_tx_demand,
    output logic                   tx_on,
    output logic                   rx_on,
    output logic                   irq_o,
    output logic [31:0]            init_addr,
    output logic [2:0]             bus_ctl,
    output logic [NUM_FILT*16-1:0] mcast_filter,
    output logic                   promisc
);
    logic [SEL_W-1:0] sel_d, sel_q;
    logic             ctrl_wr, cfg_wr;
    logic [DW-1:0]    csr0_rdata, cfg_rdata;
    logic [NFLAG-1:0] ev_vec, flags;
    logic             running, stopped, inea, intr_any;
    cmd_t             cmd;

    always_comb begin
        sel_d = sel_q;
        if (host_wr && host_addr) sel_d = host_wdata[SEL_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sel_q <= '0;
        else        sel_q <= sel_d;
    end

    assign ctrl_wr = host_wr && !host_addr && (sel_q == SEL_W'(REG_CTRL));
    assign cfg_wr  = host_wr && !host_addr && (sel_q != SEL_W'(REG_CTRL));
    assign ev_vec  = {ev_babble, ev_carrier_err, ev_missed, ev_mem_err,
                      ev_rx_int, ev_tx_int, ev_init_done};

    netctl_csr0 u_csr0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (ctrl_wr),
        .cmd_bits (host_wdata[3:0]),
        .inea_bit (host_wdata[CB_INEA]),
        .clr_bits (host_wdata[FLAG_LSB +: NFLAG]),
        .ev_set   (ev_vec),
        .cmd_o    (cmd),
        .running  (running),
        .stopped  (stopped),
        .inea     (inea),
        .flags    (flags)
    );

    netctl_cfg_regs #(
        .SEL_W     (SEL_W),
        .NUM_FILT  (NUM_FILT),
        .FILT_BASE (FILT_BASE)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_wr),
        .sel       (sel_q),
        .wdata     (host_wdata),
        .clear_bus (ctrl_wr && host_wdata[CB_STOP]),
        .rdata     (cfg_rdata),
        .init_addr (init_addr),
        .bus_ctl   (bus_ctl),
        .filt_o    (mcast_filter),
        .promisc   (promisc)
    );

    assign intr_any   = |flags;
    assign csr0_rdata = {|flags[6:3], flags, intr_any, inea, running, running,
                         1'b0, stopped, running, 1'b0};

    always_comb begin
        if (host_addr)                        host_rdata = {{(DW-SEL_W){1'b0}}, sel_q};
        else if (sel_q == SEL_W'(REG_CTRL))   host_rdata = csr0_rdata;
        else                                  host_rdata = cfg_rdata;
    end

    assign cmd_init      = cmd.init;
    assign cmd_start     = cmd.start;
    assign cmd_stop      = cmd.stop;
    assign cmd_tx_demand = cmd.tdmd;
    assign tx_on         = running;
    assign rx_on         = running;
    assign irq_o         = intr_any && inea;
endmodule

// File: rtl/netctl_regbank_chk.sv
module netctl_regbank_chk #(
    parameter int SEL_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             host_wr,
    input logic             host_addr,
    input logic             w_init,
    input logic             w_stop,
    input logic [SEL_W-1:0] sel_q,
    input logic [15:6]      csr_hi,
    input logic [1:0]       csr_on,
    input logic             cmd_init,
    input logic             cmd_start,
    input logic             cmd_stop,
    input logic             cmd_tx_demand,
    input logic             tx_on,
    input logic             rx_on,
    input logic             irq_o,
    input logic             ev_rx_int,
    input logic [2:0]       bus_ctl
);
    p_init_from_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_init |-> $past(host_wr && !host_addr && sel_q == '0 && w_init && !w_stop));

    p_stop_alone_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stop |-> (!cmd_init && !cmd_start && !cmd_tx_demand));

    p_stop_halts_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stop |-> (!tx_on && !rx_on && bus_ctl == 3'b000));

    p_run_ports_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_on == csr_on[0]) && (rx_on == csr_on[1]));

    p_event_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ev_rx_int |=> csr_hi[10]);

    p_err_summary_r8: assert property (@(posedge clk) disable iff (!rst_n)
        csr_hi[15] == (|csr_hi[14:11]));

    p_intr_summary_r8: assert property (@(posedge clk) disable iff (!rst_n)
        csr_hi[7] == (|csr_hi[14:8]));

    p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (csr_hi[7] && csr_hi[6]));
endmodule

bind netctl_regbank netctl_regbank_chk #(.SEL_W(SEL_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .host_wr       (host_wr),
    .host_addr     (host_addr),
    .w_init        (host_wdata[0]),
    .w_stop        (host_wdata[2]),
    .sel_q         (sel_q),
    .csr_hi        (csr0_rdata[15:6]),
    .csr_on        (csr0_rdata[5:4]),
    .cmd_init      (cmd_init),
    .cmd_start     (cmd_start),
    .cmd_stop      (cmd_stop),
    .cmd_tx_demand (cmd_tx_demand),
    .tx_on         (tx_on),
    .rx_on         (rx_on),
    .irq_o         (irq_o),
    .ev_rx_int     (ev_rx_int),
    .bus_ctl       (bus_ctl)
);

// File: tb/netctl_regbank_bench.sv
`timescale 1ns/1ps
module netctl_regbank_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic        host_addr = 1'b0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic ev_init_done = 0, ev_tx_int = 0, ev_rx_int = 0, ev_mem_err = 0;
    logic ev_missed = 0, ev_carrier_err = 0, ev_babble = 0;
    logic cmd_init, cmd_start, cmd_stop, cmd_tx_demand, tx_on, rx_on, irq_o;
    logic [31:0] init_addr;
    logic [2:0]  bus_ctl;
    logic [63:0] mcast_filter;
    logic        promisc;

    int n_chk = 0;
    int n_fail = 0;
    logic [15:0] rv;

    always #2.5 clk = ~clk;

    netctl_regbank u_netctl_regbank (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .ev_init_done(ev_init_done), .ev_tx_int(ev_tx_int), .ev_rx_int(ev_rx_int),
        .ev_mem_err(ev_mem_err), .ev_missed(ev_missed),
        .ev_carrier_err(ev_carrier_err), .ev_babble(ev_babble),
        .cmd_init(cmd_init), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
        .cmd_tx_demand(cmd_tx_demand), .tx_on(tx_on), .rx_on(rx_on),
        .irq_o(irq_o), .init_addr(init_addr), .bus_ctl(bus_ctl),
        .mcast_filter(mcast_filter), .promisc(promisc)
    );

    // {select, write data, expected readback}
    localparam int NVEC = 13;
    localparam logic [35:0] VECS [NVEC] = '{
        {4'd1,  16'hBEEF, 16'hBEEF},   // R9
        {4'd2,  16'h00A5, 16'h00A5},   // R9
        {4'd3,  16'hFFFF, 16'h0007},   // R10
        {4'd8,  16'h1234, 16'h1234},   // R11
        {4'd9,  16'h5678, 16'h5678},   // R11
        {4'd10, 16'h9ABC, 16'h9ABC},   // R11
        {4'd11, 16'hDEF0, 16'hDEF0},   // R11
        {4'd15, 16'hFFFF, 16'h8000},   // R12
        {4'd5,  16'hFFFF, 16'h0000},   // R12
        {4'd0,  16'h00B0, 16'h0004},   // R6 read-only bits ignored
        {4'd0,  16'h0003, 16'h0032},   // R5
        {4'd0,  16'h0040, 16'h0072},   // R6
        {4'd0,  16'h0004, 16'h0004}    // R4
    };

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [15:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] s, output logic [15:0] v);
        wr(1'b1, {12'h000, s});
        host_addr = 1'b0;
        #1 v = host_rdata;
    endtask

    task automatic pulse_rx;   @(negedge clk); ev_rx_int  = 1; @(negedge clk); ev_rx_int  = 0; endtask
    task automatic pulse_mem;  @(negedge clk); ev_mem_err = 1; @(negedge clk); ev_mem_err = 0; endtask
    task automatic pulse_bab;  @(negedge clk); ev_babble  = 1; @(negedge clk); ev_babble  = 0; endtask
    task automatic pulse_tx;   @(negedge clk); ev_tx_int  = 1; @(negedge clk); ev_tx_int  = 0; endtask

    initial begin
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2 reset state
        host_addr = 1'b1; #1;
        check("R2 select after reset", host_rdata, 16'h0000);
        host_addr = 1'b0; #1;
        check("R2 reg0 after reset", host_rdata, 16'h0004);
        check("R2 outputs after reset",
              {cmd_init, cmd_start, cmd_stop, cmd_tx_demand, tx_on, rx_on, irq_o, promisc},
              8'h00);

        // table walk: R1 select/data access plus register semantics
        for (int i = 0; i < NVEC; i++) begin
            wr(1'b1, {12'h000, VECS[i][35:32]});
            wr(1'b0, VECS[i][31:16]);
            rd(VECS[i][35:32], rv);
            check($sformatf("R1 vector %0d sel %0d", i, VECS[i][35:32]), rv, VECS[i][15:0]);
        end
        check("R9 init_addr port", init_addr, 32'h00A5BEEF);
        check("R11 filter port", mcast_filter, 64'hDEF09ABC56781234);
        check("R12 promisc port", promisc, 1'b1);
        check("R4 bus_ctl cleared by stop", bus_ctl, 3'b000);
        rd(4'd3, rv);
        check("R4 reg3 reads zero after stop", rv, 16'h0000);

        // R3 command pulses
        rd(4'd0, rv);
        wr(1'b0, 16'h000B);
        check("R3 pulses init/start/tdmd", {cmd_init, cmd_start, cmd_stop, cmd_tx_demand}, 4'b1101);
        check("R5 run outputs", {tx_on, rx_on}, 2'b11);
        rd(4'd0, rv);
        check("R3 pulses one cycle", {cmd_init, cmd_start, cmd_tx_demand}, 3'b000);
        check("R3 init/tdmd read zero", rv, 16'h0032);

        // R4 stop dominates init
        wr(1'b0, 16'h0005);
        check("R4 only stop pulses", {cmd_init, cmd_start, cmd_stop, cmd_tx_demand}, 4'b0010);
        check("R4 run outputs low", {tx_on, rx_on}, 2'b00);
        rd(4'd0, rv);
        check("R4 init+stop reads stop", rv, 16'h0004);

        // R7/R8 events and interrupt
        wr(1'b0, 16'h0042);
        pulse_rx;
        rd(4'd0, rv);
        check("R7 rx event sets bit10", rv, 16'h04F2);
        check("R8 irq with enable", irq_o, 1'b1);
        pulse_mem;
        rd(4'd0, rv);
        check("R8 err summary", rv, 16'h8CF2);
        wr(1'b0, 16'h0440);
        rd(4'd0, rv);
        check("R7 clear rx flag", rv, 16'h88F2);
        check("R8 irq held by merr", irq_o, 1'b1);
        wr(1'b0, 16'h0840);
        rd(4'd0, rv);
        check("R8 all clear", rv, 16'h0072);
        check("R8 irq drops", irq_o, 1'b0);
        pulse_bab;
        wr(1'b0, 16'h0040);
        rd(4'd0, rv);
        check("R7 write zero keeps flag", rv, 16'hC0F2);
        wr(1'b0, 16'h0000);
        rd(4'd0, rv);
        check("R8 intr without enable", rv, 16'hC0B2);
        check("R8 irq gated off", irq_o, 1'b0);
        wr(1'b0, 16'h4000);
        rd(4'd0, rv);
        check("R7 babble cleared", rv, 16'h0032);

        // R7 event beats simultaneous clear
        pulse_tx;
        @(negedge clk);
        host_wr = 1'b1; host_addr = 1'b0; host_wdata = 16'h0200; ev_tx_int = 1'b1;
        @(negedge clk);
        host_wr = 1'b0; ev_tx_int = 1'b0;
        #1 check("R7 event wins over clear", host_rdata, 16'h02B2);

        // R1 select readback
        wr(1'b1, 16'h000B);
        host_addr = 1'b1; #1;
        check("R1 select readback", host_rdata, 16'h000B);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule